// File: doc/BRIEF.md
# Dual 12-bit DAC Word Register with Staged Commit

This block sits between a byte-wide CPU write port and two 12-bit digital-to-analog converters. A 12-bit DAC word cannot arrive in one byte, so each converter is written with two byte writes. The lower eight bits are parked in a holding stage and stay hidden from the converter. The write that carries the top four bits then moves the whole word into the converter's input register in one clock edge. The converter therefore never sees a half-updated word, which would otherwise cause a glitch at its output.

The block decodes an eight-location window. The lower half of the window is not used by this block. In the upper half, address bit 1 picks the converter and address bit 0 picks the byte. A per-converter mode input selects the coding. In signed mode the word is two's complement, and the block flips bit 11 so the converter receives offset binary. In unsigned mode the word is passed through unchanged as straight binary. Each converter also has a one-cycle load strobe that marks every commit.

Top module: `dac_pair_regs`

## Requirements
- R1: A synchronous active-low reset clears both holding bytes and both stored words to 0. In the reset state both load strobes are low, and each code output reads 0x800 in signed mode or 0x000 in unsigned mode.
- R2: A write to a low-byte location (offset 4 for converter A, offset 6 for converter B) captures wr_data into that converter's holding byte. It leaves the code outputs unchanged and raises no load strobe.
- R3: A write to a high-byte location (offset 5 for A, offset 7 for B) sets the stored word to {wr_data[3:0], holding byte} at that clock edge. The matching load strobe is then high for exactly the one following cycle.
- R4: On a high-byte write, wr_data[7:4] have no effect on the stored word.
- R5: Address bit 1 selects the converter (0 selects A, 1 selects B). A write to one converter leaves the other converter's code output unchanged and its strobe low.
- R6: When unipolar_mode[n] is 0 (signed), code output n equals the stored word with bit 11 inverted, so 0x7FF gives 0xFFF and 0x800 gives 0x000. When unipolar_mode[n] is 1, the code output equals the stored word.
- R7: A high-byte write that is not preceded by a new low-byte write reuses the most recently captured holding byte.
- R8: Writes to offsets 0 to 3, and any cycle with wr_en low, change neither the holding bytes nor the stored words, and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 3 | Offset of the write within the window |
| wr_data | input | 8 | Write data byte |
| unipolar_mode | input | 2 | Coding select per converter: 1 means straight binary, 0 means two's complement |
| dac_a_code | output | 12 | Code presented to converter A |
| dac_b_code | output | 12 | Code presented to converter B |
| dac_a_load | output | 1 | One-cycle pulse after each commit to A |
| dac_b_load | output | 1 | One-cycle pulse after each commit to B |

## Verification
The bench writes a lone low byte and checks that the output does not move. It then writes a high byte whose upper nibble is nonzero, which separates correct masking from a plain 8-bit copy. Writes to converter B with A already holding a known word show whether the two channels are kept apart. A second high write with no new low byte checks that the held byte is reused rather than cleared. The coding is checked with the extreme words 0x7FF and 0x800 in signed mode, and with stray writes to the unused offsets and with wr_en low followed by a commit, which would expose a corrupted holding byte.

// File: rtl/dac_pair_pkg.sv
// Package: shared widths and types for the dual DAC word register.
// Assumes a byte-wide write port and words no wider than two bytes.
package dac_pair_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 12;
    localparam int HI_W    = WORD_W - BYTE_W;
    localparam int NUM_DAC = 2;
    localparam int ADDR_W  = 3;

    typedef logic [WORD_W-1:0] dac_word_t;
endpackage

// File: rtl/dac_hold_stage.sv
// Holding stage: stores the low byte of a DAC word until the high write commits it.
// Assumes lo_we is a single-cycle decoded write enable.
module dac_hold_stage #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic [BYTE_W-1:0] data_i,
    output logic [BYTE_W-1:0] low_q
);
    // Capture the low byte on its own write; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     low_q <= '0;
        else if (lo_we) low_q <= data_i;
    end

    p_low_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> low_q == $past(data_i));
    p_low_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_we |=> $stable(low_q));
endmodule

// File: rtl/dac_commit_stage.sv
// Commit stage: loads the full DAC word in one edge and pulses a load strobe.
// Assumes hi_we is a single-cycle decoded write enable.
module dac_commit_stage #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 12,
    localparam int HI_W  = WORD_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_we,
    input  logic [HI_W-1:0]   hi_nib_i,
    input  logic [BYTE_W-1:0] low_i,
    output logic [WORD_W-1:0] word_q,
    output logic              load_q
);
    // Move the upper bits and the held low byte into the word together.
    always_ff @(posedge clk) begin
        if (!rst_n)     word_q <= '0;
        else if (hi_we) word_q <= {hi_nib_i, low_i};
    end

    // Flag each commit for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= hi_we;
    end

    p_commit_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_we |=> word_q == {$past(hi_nib_i), $past(low_i)});
    p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |=> !load_q || $past(hi_we));
    p_word_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_we |=> $stable(word_q) && !load_q);
endmodule

// File: rtl/dac_code_map.sv
// Code map: converts a stored word to the coding the converter expects.
// Signed words become offset binary by inverting the top bit; unsigned words pass through.
module dac_code_map #(
    parameter int WORD_W = 12
) (
    input  logic              unipolar_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] code_o
);
    // Select pass-through or top-bit inversion.
    always_comb begin
        code_o = word_i;
        if (!unipolar_i) code_o[WORD_W-1] = ~word_i[WORD_W-1];
    end
endmodule

// File: rtl/dac_pair_regs.sv
// Top: decodes byte writes into two staged DAC word registers.
// Assumes the upper half of the window holds the DAC bytes; bit 1 picks the DAC, bit 0 the byte.
module dac_pair_regs
    import dac_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [NUM_DAC-1:0] unipolar_mode,
    output logic [WORD_W-1:0] dac_a_code,
    output logic [WORD_W-1:0] dac_b_code,
    output logic              dac_a_load,
    output logic              dac_b_load
);
    localparam int SEL_W = (NUM_DAC > 1) ? $clog2(NUM_DAC) : 1;

    logic              win_hit;
    logic              is_hi;
    logic [SEL_W-1:0]  dac_sel;
    logic [NUM_DAC-1:0] lo_we, hi_we, load_vec;
    logic [BYTE_W-1:0] low_vec  [NUM_DAC];
    dac_word_t         word_vec [NUM_DAC];
    dac_word_t         code_vec [NUM_DAC];

    // Decode the window and the byte and DAC selects.
    always_comb begin
        win_hit = wr_en && wr_addr[ADDR_W-1];
        is_hi   = wr_addr[0];
        dac_sel = wr_addr[SEL_W:1];
    end

    for (genvar g = 0; g < NUM_DAC; g++) begin : g_dac
        // Per-DAC write enables.
        always_comb begin
            lo_we[g] = win_hit && !is_hi && (dac_sel == SEL_W'(g));
            hi_we[g] = win_hit &&  is_hi && (dac_sel == SEL_W'(g));
        end

        dac_hold_stage #(.BYTE_W(BYTE_W)) u_hold (
            .clk(clk), .rst_n(rst_n), .lo_we(lo_we[g]),
            .data_i(wr_data), .low_q(low_vec[g]));

        dac_commit_stage #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_commit (
            .clk(clk), .rst_n(rst_n), .hi_we(hi_we[g]),
            .hi_nib_i(wr_data[HI_W-1:0]), .low_i(low_vec[g]),
            .word_q(word_vec[g]), .load_q(load_vec[g]));

        dac_code_map #(.WORD_W(WORD_W)) u_map (
            .unipolar_i(unipolar_mode[g]), .word_i(word_vec[g]),
            .code_o(code_vec[g]));

        p_other_dac_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (win_hit && dac_sel != SEL_W'(g)) |=> $stable(word_vec[g]) && !load_vec[g]);
        p_signed_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !unipolar_mode[g] |-> code_vec[g][WORD_W-1] != word_vec[g][WORD_W-1]);
    end

    assign dac_a_code = code_vec[0];
    assign dac_b_code = code_vec[1];
    assign dac_a_load = load_vec[0];
    assign dac_b_load = load_vec[1];

    p_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr[ADDR_W-1]) |=> !dac_a_load && !dac_b_load);
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dac_a_load, dac_b_load}));
endmodule

// File: tb/dac_pair_regs_tb_top.sv
// Directed bench for the dual DAC word register.
module dac_pair_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [1:0]  unipolar_mode;
    logic [11:0] dac_a_code, dac_b_code;
    logic        dac_a_load, dac_b_load;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    dac_pair_regs dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .unipolar_mode(unipolar_mode),
        .dac_a_code(dac_a_code), .dac_b_code(dac_b_code),
        .dac_a_load(dac_a_load), .dac_b_load(dac_b_load));

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one write at a falling edge; returns at the next falling edge.
    task automatic wr(input logic en, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        unipolar_mode = 2'b00; #1;
        chk("R1 signed A", dac_a_code, 12'h800);
        chk("R1 signed B", dac_b_code, 12'h800);
        chk("R1 strobes", {10'd0, dac_a_load, dac_b_load}, 12'h000);
        unipolar_mode = 2'b11; #1;
        chk("R1 unsigned A", dac_a_code, 12'h000);
    endtask

    task automatic t_low_only;
        wr(1'b1, 3'd4, 8'hA5);
        chk("R2 code A", dac_a_code, 12'h000);
        chk("R2 load A", {11'd0, dac_a_load}, 12'h000);
    endtask

    task automatic t_commit;
        wr(1'b1, 3'd5, 8'h03);
        chk("R3 code A", dac_a_code, 12'h3A5);
        chk("R3 load A", {11'd0, dac_a_load}, 12'h001);
        chk("R3 load B", {11'd0, dac_b_load}, 12'h000);
        @(negedge clk);
        chk("R3 pulse width", {11'd0, dac_a_load}, 12'h000);
    endtask

    task automatic t_upper_ignored;
        wr(1'b1, 3'd5, 8'hF7);
        chk("R4 code A", dac_a_code, 12'h7A5);
    endtask

    task automatic t_select;
        wr(1'b1, 3'd6, 8'h5C);
        chk("R5 B low hidden", dac_b_code, 12'h000);
        wr(1'b1, 3'd7, 8'h0E);
        chk("R5 code B", dac_b_code, 12'hE5C);
        chk("R5 load B", {11'd0, dac_b_load}, 12'h001);
        chk("R5 A untouched", dac_a_code, 12'h7A5);
        chk("R5 no load A", {11'd0, dac_a_load}, 12'h000);
    endtask

    task automatic t_reuse_low;
        wr(1'b1, 3'd7, 8'h01);
        chk("R7 code B", dac_b_code, 12'h15C);
    endtask

    task automatic t_coding;
        unipolar_mode = 2'b00; #1;
        chk("R6 signed A", dac_a_code, 12'hFA5);
        chk("R6 signed B", dac_b_code, 12'h95C);
        wr(1'b1, 3'd4, 8'hFF);
        wr(1'b1, 3'd5, 8'h07);
        chk("R6 max positive", dac_a_code, 12'hFFF);
        wr(1'b1, 3'd4, 8'h00);
        wr(1'b1, 3'd5, 8'h08);
        chk("R6 max negative", dac_a_code, 12'h000);
        unipolar_mode = 2'b11; #1;
        chk("R6 unsigned pass", dac_a_code, 12'h800);
    endtask

    task automatic t_ignored;
        wr(1'b1, 3'd4, 8'h3C);
        wr(1'b1, 3'd5, 8'h01);
        chk("R8 setup", dac_a_code, 12'h13C);
        for (int i = 0; i < 4; i++) begin
            wr(1'b1, 3'(i), 8'hFF);
            chk("R8 no load", {10'd0, dac_a_load, dac_b_load}, 12'h000);
        end
        wr(1'b0, 3'd4, 8'h99);
        wr(1'b0, 3'd5, 8'h0F);
        chk("R8 no load idle", {10'd0, dac_a_load, dac_b_load}, 12'h000);
        chk("R8 A unchanged", dac_a_code, 12'h13C);
        chk("R8 B unchanged", dac_b_code, 12'h15C);
        wr(1'b1, 3'd5, 8'h02);
        chk("R8 hold intact", dac_a_code, 12'h23C);
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 rerun A", dac_a_code, 12'h000);
        chk("R1 rerun B", dac_b_code, 12'h000);
        wr(1'b1, 3'd5, 8'h04);
        chk("R1 hold cleared", dac_a_code, 12'h400);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        unipolar_mode = 2'b00;
        t_reset();
        t_low_only();
        t_commit();
        t_upper_ignored();
        t_select();
        t_reuse_low();
        t_coding();
        t_ignored();
        t_reset_again();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule